// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that moves bytes or halfwords between memory and one device FIFO. It owns two buffer slots, each holding a current address and a remaining unit count. A pointer selects the slot in service. When that slot drains, the channel marks it finished and moves to the other slot without a gap. Software therefore refills one slot while the other runs, and keeps a stream going with no dead time between buffers.

The control/status byte cannot be written directly. One register index ORs ones into it, a second clears ones, and a third reads it. Status flags therefore change only through explicit set and clear masks, and a read-modify-write from software cannot race the hardware. Each data unit is one memory request/acknowledge handshake. A device request input lets a burst start, and the burst carries the configured length or the remaining count, whichever is smaller. An interrupt output reports finished buffers and memory errors.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset the status byte, the config word and both slots read 0, and `irq_o` and `mem_req_o` are low.
- R2: Status byte bit positions: 0 run, 1 interrupt enable, 2 error, 3 slot A done, 4 slot A start, 5 slot B done, 6 slot B start, 7 slot pointer (0 = A). Register index 1 ORs in write-data bits 0, 1, 4 and 6. Index 2 clears the write-data bits 0 to 6 that are 1. Index 3 reads the byte, zero-extended. Software writes never change bit 7.
- R3: While run and the current slot's start bit are both set, that slot is serviced. When its count is 0, the channel clears its start bit, sets its done bit and inverts the slot pointer, all in one cycle. It then services the other slot at once if that slot's start bit is set.
- R4: Each acknowledged unit adds 1 to the slot address (config bit 3 = 0, bytes) or 2 (bit 3 = 1, halfwords), and subtracts 1 from the count. `mem_we_o` equals config bit 0 (1 = device to memory), and `mem_hword_o` equals config bit 3.
- R5: A burst starts only when `dev_req_i` is seen while the channel is idle. Its length is 8 units if config bit 2 is 1, otherwise 4, or the remaining count if that is smaller. After a burst the channel waits for a new device request.
- R6: A started slot with a count of 0 finishes without raising `mem_req_o`.
- R7: `irq_o` is high exactly while interrupt enable is set and at least one of error, A done or B done is set. These flags hold until they are cleared through index 2.
- R8: Clearing run drops `mem_req_o` in the same cycle and keeps the start bits, addresses and counts. Setting run again resumes the transfer from where it stopped.
- R9: An acknowledge that comes with `mem_err_i` sets error and clears run, and leaves the address and the count unchanged.
- R10: Index 0 writes and reads the config word. Indexes 4 and 6 load and read the current address of slot A and slot B. Indexes 5 and 7 load and read their remaining counts. Config bits 7:4 drive `dev_sel_o`, bits 31:8 drive `dev_port_o`, and bit 1 drives `mem_big_o`.
- R11: A count register keeps 13 bits, so the largest count is 0x1FFF and higher write bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_widx_i | input | 3 | Register word index (byte offset / 4) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the indexed register (combinational) |
| dev_req_i | input | 1 | Device ready for a burst |
| dev_sel_o | output | 4 | Selected device code |
| dev_port_o | output | 24 | Device port address |
| mem_req_o | output | 1 | Memory unit request |
| mem_addr_o | output | 32 | Address of the current unit |
| mem_we_o | output | 1 | 1 = write memory (device to memory) |
| mem_hword_o | output | 1 | 1 = halfword unit |
| mem_big_o | output | 1 | Big-endian lane order |
| mem_ack_i | input | 1 | Memory accepted the unit |
| mem_err_i | input | 1 | Error qualifier for the acknowledge |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check on every cycle the properties that depend only on the current state. The slot pointer moves only on a finish and always flips when one happens. No request goes out on an empty slot or while run is clear. An accepted unit lowers the count by one, and an errored acknowledge leaves error set with run cleared. The interrupt follows its enable. Only the bench scenarios can show sequence-level results: the exact address lists across a slot change, burst lengths limited by the device request, a pause followed by a resume that ends at the right address, and the final addresses and counts over random widths, burst sizes and zero counts.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam logic [2:0] OFS_CFG    = 3'd0;
  localparam logic [2:0] OFS_SET    = 3'd1;
  localparam logic [2:0] OFS_CLR    = 3'd2;
  localparam logic [2:0] OFS_STAT   = 3'd3;
  localparam logic [2:0] OFS_ADDR_A = 3'd4;
  localparam logic [2:0] OFS_CNT_A  = 3'd5;
  localparam logic [2:0] OFS_ADDR_B = 3'd6;
  localparam logic [2:0] OFS_CNT_B  = 3'd7;

  localparam int B_RUN     = 0;
  localparam int B_IE      = 1;
  localparam int B_ERR     = 2;
  localparam int B_DONE_A  = 3;
  localparam int B_START_A = 4;
  localparam int B_DONE_B  = 5;
  localparam int B_START_B = 6;
  localparam int B_BIU     = 7;

  localparam logic [7:0] SET_MASK = 8'h53;
  localparam logic [7:0] CLR_MASK = 8'h7F;

  typedef enum logic {S_IDLE, S_XFER} seq_state_e;
endpackage

// File: rtl/pp_dma_buf.sv
module pp_dma_buf #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic              step2_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] step;
  assign step = {{(ADDR_W-2){1'b0}}, step2_i, ~step2_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else begin
      if (ld_addr_i)  addr_o <= wdata_i;
      else if (adv_i) addr_o <= addr_o + step;
      if (ld_cnt_i)   cnt_o  <= wdata_i[CNT_W-1:0];
      else if (adv_i) cnt_o  <= cnt_o - CNT_ONE;
    end
  end
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq import pp_dma_pkg::*; #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             burst8_i,
  input  logic             dev_req_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  output logic             mem_req_o,
  output logic             adv_o,
  output logic             err_o,
  output logic             fin_o
);
  localparam int unsigned LEFT_W = 4;

  seq_state_e state_q, state_d;
  logic [LEFT_W-1:0] left_q, left_d, blen;
  logic [CNT_W-1:0] bsz;
  logic go;

  assign go   = run_i & start_i;
  assign bsz  = {{(CNT_W-4){1'b0}}, burst8_i, ~burst8_i, 2'b00};
  assign blen = (cnt_i < bsz) ? cnt_i[LEFT_W-1:0] : bsz[LEFT_W-1:0];

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    mem_req_o = 1'b0;
    adv_o     = 1'b0;
    err_o     = 1'b0;
    fin_o     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (go) begin
          if (cnt_i == '0) fin_o = 1'b1;
          else if (dev_req_i) begin
            state_d = S_XFER;
            left_d  = blen;
          end
        end
      end
      S_XFER: begin
        if (!go) state_d = S_IDLE;
        else begin
          mem_req_o = 1'b1;
          if (mem_ack_i) begin
            if (mem_err_i) begin
              err_o   = 1'b1;
              state_d = S_IDLE;
            end else begin
              adv_o  = 1'b1;
              left_d = left_q - 4'd1;
              if (left_q == 4'd1) state_d = S_IDLE;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan import pp_dma_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_widx_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              dev_req_i,
  output logic [3:0]        dev_sel_o,
  output logic [REG_W-9:0]  dev_port_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_hword_o,
  output logic              mem_big_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              irq_o
);
  logic [REG_W-1:0]  cfg_q;
  logic [7:0]        csr_q, csr_d;
  logic [ADDR_W-1:0] addr_w [2];
  logic [CNT_W-1:0]  cnt_w  [2];
  logic [CNT_W-1:0]  cnt_cur;
  logic cur, adv, fin, seq_err, start_cur;
  logic wr_cfg, wr_set, wr_clr;

  assign cur       = csr_q[B_BIU];
  assign cnt_cur   = cnt_w[cur];
  assign start_cur = cur ? csr_q[B_START_B] : csr_q[B_START_A];
  assign wr_cfg    = reg_we_i && (reg_widx_i == OFS_CFG);
  assign wr_set    = reg_we_i && (reg_widx_i == OFS_SET);
  assign wr_clr    = reg_we_i && (reg_widx_i == OFS_CLR);

  for (genvar b = 0; b < 2; b++) begin : g_buf
    localparam logic [2:0] IDX_ADDR = (b == 0) ? OFS_ADDR_A : OFS_ADDR_B;
    localparam logic [2:0] IDX_CNT  = (b == 0) ? OFS_CNT_A  : OFS_CNT_B;
    localparam logic       SEL      = (b == 0) ? 1'b0 : 1'b1;
    pp_dma_buf #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_addr_i (reg_we_i && (reg_widx_i == IDX_ADDR)),
      .ld_cnt_i  (reg_we_i && (reg_widx_i == IDX_CNT)),
      .wdata_i   (reg_wdata_i[ADDR_W-1:0]),
      .adv_i     (adv && (cur == SEL)),
      .step2_i   (cfg_q[3]),
      .addr_o    (addr_w[b]),
      .cnt_o     (cnt_w[b])
    );
  end

  pp_dma_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (csr_q[B_RUN]),
    .start_i   (start_cur),
    .cnt_i     (cnt_cur),
    .burst8_i  (cfg_q[2]),
    .dev_req_i (dev_req_i),
    .mem_ack_i (mem_ack_i),
    .mem_err_i (mem_err_i),
    .mem_req_o (mem_req_o),
    .adv_o     (adv),
    .err_o     (seq_err),
    .fin_o     (fin)
  );

  // hardware events first, then software clear, then software set
  always_comb begin
    csr_d = csr_q;
    if (fin) begin
      if (cur) begin
        csr_d[B_START_B] = 1'b0;
        csr_d[B_DONE_B]  = 1'b1;
      end else begin
        csr_d[B_START_A] = 1'b0;
        csr_d[B_DONE_A]  = 1'b1;
      end
      csr_d[B_BIU] = ~cur;
    end
    if (seq_err) begin
      csr_d[B_ERR] = 1'b1;
      csr_d[B_RUN] = 1'b0;
    end
    if (wr_clr) csr_d = csr_d & ~(reg_wdata_i[7:0] & CLR_MASK);
    if (wr_set) csr_d = csr_d | (reg_wdata_i[7:0] & SET_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
      cfg_q <= '0;
    end else begin
      csr_q <= csr_d;
      if (wr_cfg) cfg_q <= reg_wdata_i;
    end
  end

  always_comb begin
    case (reg_widx_i)
      OFS_CFG:    reg_rdata_o = cfg_q;
      OFS_STAT:   reg_rdata_o = REG_W'(csr_q);
      OFS_ADDR_A: reg_rdata_o = REG_W'(addr_w[0]);
      OFS_CNT_A:  reg_rdata_o = REG_W'(cnt_w[0]);
      OFS_ADDR_B: reg_rdata_o = REG_W'(addr_w[1]);
      OFS_CNT_B:  reg_rdata_o = REG_W'(cnt_w[1]);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign mem_addr_o  = addr_w[cur];
  assign mem_we_o    = cfg_q[0];
  assign mem_big_o   = cfg_q[1];
  assign mem_hword_o = cfg_q[3];
  assign dev_sel_o   = cfg_q[7:4];
  assign dev_port_o  = cfg_q[REG_W-1:8];
  assign irq_o = csr_q[B_IE] & (csr_q[B_ERR] | csr_q[B_DONE_A] | csr_q[B_DONE_B]);
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
  parameter int unsigned CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       csr_i,
  input logic             fin_i,
  input logic             mem_req_i,
  input logic             mem_ack_i,
  input logic             mem_err_i,
  input logic             reg_we_i,
  input logic [CNT_W-1:0] cnt_cur_i,
  input logic             irq_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r2_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(csr_i[7]));

  a_r3_ptr_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (csr_i[7] != $past(csr_i[7])));

  a_r3_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !reg_we_i) |=> (csr_i[3] || csr_i[5]));

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ack_i && !mem_err_i && !reg_we_i) |=>
      (cnt_cur_i == $past(cnt_cur_i) - ONE));

  a_r6_no_empty_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (cnt_cur_i != '0));

  a_r7_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_i[1] |-> !irq_i);

  a_r7_irq_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_i[1] && (csr_i[3] || csr_i[5])) |-> irq_i);

  a_r8_no_req_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_i[0] |-> !mem_req_i);

  a_r9_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ack_i && mem_err_i && !reg_we_i) |=> (csr_i[2] && !csr_i[0]));
endmodule

bind pp_dma_chan pp_dma_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .csr_i     (csr_q),
  .fin_i     (fin),
  .mem_req_i (mem_req_o),
  .mem_ack_i (mem_ack_i),
  .mem_err_i (mem_err_i),
  .reg_we_i  (reg_we_i),
  .cnt_cur_i (cnt_cur),
  .irq_i     (irq_o)
);

// File: tb/test_pp_dma_chan.sv
`timescale 1ns/1ps
module test_pp_dma_chan;
  import pp_dma_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_widx_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dev_req_i = 1'b0;
  logic [3:0]  dev_sel_o;
  logic [23:0] dev_port_o;
  logic        mem_req_o, mem_we_o, mem_hword_o, mem_big_o, irq_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_err_i = 1'b0;

  pp_dma_chan i_pp_dma_chan (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int units = 0, req_cycles = 0;
  bit ack_all = 1'b1, rnd_dev = 1'b0, err_arm = 1'b0;
  logic last_we, last_hw;
  logic [31:0] log_a [256];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_widx_i = i; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    reg_widx_i = i;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wait_csr(input logic [7:0] mask, input int maxc);
    logic [31:0] v;
    bit hit = 1'b0;
    for (int k = 0; k < maxc && !hit; k++) begin
      rd(OFS_STAT, v);
      if ((v[7:0] & mask) == mask) hit = 1'b1;
      else @(negedge clk_i);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] end_addr(logic [31:0] a, int c, bit hw);
    return a + c * (hw ? 2 : 1);
  endfunction

  // memory / device responder
  initial begin
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      mem_err_i = 1'b0;
      if (rnd_dev) dev_req_i = ($urandom % 3) != 0;
      if (mem_req_o) begin
        req_cycles++;
        last_we = mem_we_o;
        last_hw = mem_hword_o;
        if (ack_all || ($urandom % 2 == 0)) begin
          mem_ack_i = 1'b1;
          if (err_arm) begin
            mem_err_i = 1'b1;
            err_arm = 1'b0;
          end else begin
            log_a[units % 256] = mem_addr_o;
            units++;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog R3: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int u0, u1, rq0;
    void'($urandom(32'd1234));
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd(OFS_STAT, v); chk("R1 status", v, 32'h0);
    rd(OFS_CFG, v);  chk("R1 config", v, 32'h0);
    rd(OFS_CNT_A, v); chk("R1 count A", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req_o}, 32'h0);

    // R11 count width
    wr(OFS_CNT_A, 32'hFFFF);
    rd(OFS_CNT_A, v); chk("R11 count clip", v, 32'h1FFF);

    // R2 set/clear masks, pointer untouched, no device request -> no motion
    wr(OFS_SET, 32'hFF);
    rd(OFS_STAT, v); chk("R2 set mask", v, 32'h53);
    idle(5);
    chk("R5 no request without dev_req", {31'b0, mem_req_o}, 32'h0);
    wr(OFS_CLR, 32'hFF);
    rd(OFS_STAT, v); chk("R2 clear mask", v, 32'h0);

    // R3/R4/R10 directed: halfword, device to memory, both slots
    wr(OFS_CFG, 32'h0000_AB39);
    rd(OFS_CFG, v); chk("R10 config readback", v, 32'h0000_AB39);
    chk("R10 dev_sel", {28'b0, dev_sel_o}, 32'h3);
    chk("R10 dev_port", {8'b0, dev_port_o}, 32'h0000AB);
    wr(OFS_ADDR_A, 32'h1000); wr(OFS_CNT_A, 5);
    wr(OFS_ADDR_B, 32'h2000); wr(OFS_CNT_B, 3);
    dev_req_i = 1'b1;
    wr(OFS_SET, 32'h53);
    wait_csr(8'h28, 500);
    rd(OFS_STAT, v); chk("R3 both slots done", v, 32'h2B);
    chk("R4 unit count", units, 8);
    for (int i = 0; i < 5; i++) chk("R4 slot A address list", log_a[i], 32'h1000 + 2 * i);
    for (int i = 0; i < 3; i++) chk("R3 slot B follows A", log_a[5 + i], 32'h2000 + 2 * i);
    chk("R4 write direction", {31'b0, last_we}, 32'h1);
    chk("R4 halfword", {31'b0, last_hw}, 32'h1);
    rd(OFS_ADDR_A, v); chk("R10 addr A end", v, 32'h100A);
    rd(OFS_ADDR_B, v); chk("R10 addr B end", v, 32'h2006);
    chk("R7 irq on done", {31'b0, irq_o}, 32'h1);
    wr(OFS_CLR, 32'h28);
    rd(OFS_STAT, v); chk("R7 flags cleared", v, 32'h03);
    chk("R7 irq low after clear", {31'b0, irq_o}, 32'h0);
    dev_req_i = 1'b0;
    wr(OFS_CLR, 32'hFF);

    // R5 burst gating, burst 8, byte, memory to device
    wr(OFS_CFG, 32'h04);
    wr(OFS_ADDR_A, 32'h3000); wr(OFS_CNT_A, 20);
    u0 = units;
    wr(OFS_SET, 32'h11);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk_i); dev_req_i = 1'b1;
      @(negedge clk_i); dev_req_i = 1'b0;
      idle(30);
      chk("R5 burst length", units - u0, (p == 2) ? 20 : 8 * (p + 1));
    end
    chk("R4 read direction", {31'b0, last_we}, 32'h0);
    rd(OFS_STAT, v); chk("R3 pointer to B after A", v, 32'h89);
    rd(OFS_ADDR_A, v); chk("R4 byte step", v, 32'h3014);
    wr(OFS_CLR, 32'hFF);
    rd(OFS_STAT, v); chk("R2 clear keeps pointer", v, 32'h80);

    // R6 zero counts
    wr(OFS_CNT_A, 0); wr(OFS_CNT_B, 0);
    rq0 = req_cycles;
    dev_req_i = 1'b1;
    wr(OFS_SET, 32'h51);
    idle(6);
    rd(OFS_STAT, v); chk("R6 zero count finish", v, 32'hA9);
    chk("R6 no request", req_cycles, rq0);
    wr(OFS_CLR, 32'hFF);

    // R8 pause and resume on slot B
    wr(OFS_CFG, 32'h00);
    wr(OFS_ADDR_B, 32'h4000); wr(OFS_CNT_B, 200);
    ack_all = 1'b0;
    u0 = units;
    wr(OFS_SET, 32'h41);
    idle(40);
    wr(OFS_CLR, 32'h01);
    chk("R8 request drops", {31'b0, mem_req_o}, 32'h0);
    u1 = units - u0;
    idle(30);
    chk("R8 no progress paused", units - u0, u1);
    rd(OFS_STAT, v); chk("R8 start kept", v, 32'hC0);
    rd(OFS_CNT_B, v); chk("R10 remaining count", v, 200 - u1);
    rd(OFS_ADDR_B, v); chk("R10 current address", v, 32'h4000 + u1);
    wr(OFS_SET, 32'h01);
    wait_csr(8'h20, 3000);
    chk("R8 resume total", units - u0, 200);
    rd(OFS_ADDR_B, v); chk("R8 resume end address", v, 32'h40C8);
    rd(OFS_STAT, v); chk("R3 pointer back to A", v, 32'h21);
    wr(OFS_CLR, 32'hFF);

    // R9 memory error
    ack_all = 1'b1;
    wr(OFS_ADDR_A, 32'h5000); wr(OFS_CNT_A, 10);
    u0 = units;
    wr(OFS_SET, 32'h13);
    while (units - u0 < 3) @(negedge clk_i);
    err_arm = 1'b1;
    idle(10);
    rd(OFS_STAT, v); chk("R9 error stops", v, 32'h16);
    chk("R7 irq on error", {31'b0, irq_o}, 32'h1);
    rd(OFS_CNT_A, v); chk("R9 count not taken", v, 10 - (units - u0));
    rd(OFS_ADDR_A, v); chk("R9 address not taken", v, 32'h5000 + (units - u0));
    wr(OFS_CLR, 32'hFF);
    chk("R7 irq cleared", {31'b0, irq_o}, 32'h0);

    // random: widths, bursts, directions, counts incl. zero, random device and memory timing
    rnd_dev = 1'b1;
    ack_all = 1'b0;
    for (int it = 0; it < 16; it++) begin
      logic [31:0] cfg, aa, ab;
      int ca, cb;
      cfg = $urandom & 32'hFFFF_FFFD;
      ca = $urandom % 41;
      cb = $urandom % 41;
      aa = ($urandom & 32'h00FF_FFFE);
      ab = ($urandom & 32'h00FF_FFFE);
      wr(OFS_CFG, cfg);
      chk("R10 random dev_sel", {28'b0, dev_sel_o}, {28'b0, cfg[7:4]});
      wr(OFS_ADDR_A, aa); wr(OFS_CNT_A, ca);
      wr(OFS_ADDR_B, ab); wr(OFS_CNT_B, cb);
      u0 = units;
      wr(OFS_SET, 32'h51);
      wait_csr(8'h28, 3000);
      rd(OFS_STAT, v); chk("R3 random done, pointer kept", v, 32'h29);
      chk("R4 random units", units - u0, ca + cb);
      rd(OFS_ADDR_A, v); chk("R4 random end A", v, end_addr(aa, ca, cfg[3]));
      rd(OFS_ADDR_B, v); chk("R4 random end B", v, end_addr(ab, cb, cfg[3]));
      rd(OFS_CNT_B, v); chk("R4 random count B", v, 32'h0);
      wr(OFS_CLR, 32'hFF);
    end
    rnd_dev = 1'b0;
    dev_req_i = 1'b0;

    summary();
    $finish;
  end
endmodule